// File: doc/BRIEF.md
# Shared-Bus Serial Clock Pacer

This block produces the serial clock for one controller on a two-wire open-drain bus. Several controllers, and any target, may pull the clock line low at the same moment, and the line is the wired-AND of all of them. The block does not impose its own period. It counts a programmable low time and a programmable high time in system clock cycles, but it re-synchronises to the line on every transition. A falling edge that any device causes starts the block's own low count. The high count starts only once the line has really been seen high. So the slowest device stretches the low phase, and the fastest device cuts the high phase short.

The block also watches the data line. When the block leaves data released (a logic 1) but the sampled data line reads low during the clock-high phase, another controller has won the bus. The block raises a sticky lost flag and stops driving both lines. The byte-level sequencer above it supplies the next data bit on `sda_bit`. It changes that bit on the shift strobe early in each low phase and reads the bus on the sample strobe after each rising edge. Both bus inputs pass through a two-flop synchroniser before any decision is made.

Top module: `scl_pacer`

## Requirements
- R1: While reset is asserted and just after it, `scl_pull`, `sda_pull`, `sample_stb`, `shift_stb` and `arb_lost` are all 0.
- R2: When the block starts a low phase, it holds `scl_pull` high for exactly `low_reload` cycles. `shift_stb` is 1 in the first of those cycles.
- R3: After the block releases the clock, the high phase it counts begins only when the synchronised line is seen rising. With no other device active, the line stays high for `high_reload` + 3 cycles: two synchroniser stages plus one detect cycle. `sample_stb` is 1 in the fourth cycle of the high phase, and `sample_stb` and `shift_stb` are never 1 together.
- R4: If another device keeps the clock low after the block has released it, the block waits without limit. The following high phase still lasts `high_reload` + 3 cycles, measured from the moment the line rises.
- R5: If another device pulls the clock low during the block's high phase, the block starts its low phase 3 cycles later. From that point it pulls the line for `low_reload` cycles, and `shift_stb` is 1 in the fourth cycle of that low phase.
- R6: While arbitration has not been lost, `sda_pull` is 1 exactly when `sda_bit` is 0.
- R7: If `sda_bit` is 1 while the sampled data line is 0 during the block's high phase, `arb_lost` becomes 1. From then on `scl_pull` and `sda_pull` stay 0 while `run_en` remains 1, whatever the value of `sda_bit`.
- R8: When `run_en` is 0, the block finishes the current low and high phases and then releases the clock and stays idle. It starts no new low phase.
- R9: `arb_lost` holds while `run_en` is 1 and clears one cycle after `run_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Clocking enable; when low, the block stops after the current high phase |
| low_reload | input | CNT_W | Low-phase length in cycles (at least 1) |
| high_reload | input | CNT_W | High-phase count in cycles (at least 1) |
| scl_in | input | 1 | Clock line level read from the bus |
| sda_in | input | 1 | Data line level read from the bus |
| sda_bit | input | 1 | Data bit to place on the bus (1 = released) |
| scl_pull | output | 1 | Pull the clock line low |
| sda_pull | output | 1 | Pull the data line low |
| sample_stb | output | 1 | One-cycle strobe after a clock rise is detected |
| shift_stb | output | 1 | One-cycle strobe when a low phase begins |
| arb_lost | output | 1 | Sticky arbitration-lost flag |

## Verification
The assertions assume that `sda_bit` changes only around `shift_stb`, so it is steady through each high phase. They also assume that reload values are at least 1 and that any other device pulling the clock keeps it low for at least one full cycle. The stimulus keeps to these limits. Reload values change only while the bench is not scoring phases. Every external pull is applied just after a clock edge and held for whole cycles. The data bit is set only while the block is idle or between scored phases.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // A released (1) data bit that reads back low while the clock is high
  // means another controller drove a 0.
  function automatic logic arb_conflict(input logic drive_one,
                                        input logic seen_level,
                                        input logic clock_high);
    return drive_one & ~seen_level & clock_high;
  endfunction

endpackage

// File: rtl/scl_pacer_sync.sv
module scl_pacer_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] level
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= (chain << 1) | STAGES'(raw[g]);
    end
    assign level[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/scl_pacer_edge.sv
module scl_pacer_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;

endmodule

// File: rtl/scl_pacer_timer.sv
module scl_pacer_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - W'(1);
  end

  // A reload of 0 behaves as 1.
  assign expired = (cnt <= W'(1));

endmodule

// File: rtl/scl_pacer.sv
module scl_pacer
  import scl_pacer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] low_reload,
  input  logic [CNT_W-1:0] high_reload,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             sda_bit,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             sample_stb,
  output logic             shift_stb,
  output logic             arb_lost
);

  localparam int NLINES  = 2;
  localparam int IDX_SCL = 0;
  localparam int IDX_SDA = 1;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] sync_lines;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall;

  assign raw_lines = {sda_in, scl_in};

  scl_pacer_sync #(.STAGES(SYNC_STAGES), .LINES(NLINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (raw_lines),
    .level (sync_lines)
  );

  assign scl_lvl = sync_lines[IDX_SCL];
  assign sda_lvl = sync_lines[IDX_SDA];

  scl_pacer_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (scl_lvl),
    .rise  (scl_rise),
    .fall  (scl_fall)
  );

  phase_e ph, ph_nx;
  logic t_load, t_sel_low, t_dec, t_expired;
  logic [CNT_W-1:0] t_val;
  logic in_high, conflict;

  assign t_val = t_sel_low ? low_reload : high_reload;

  scl_pacer_timer #(.W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .dec      (t_dec),
    .expired  (t_expired)
  );

  assign in_high  = (ph == PH_HIGH);
  assign conflict = arb_conflict(sda_bit, sda_lvl, in_high);

  always_comb begin
    ph_nx     = ph;
    t_load    = 1'b0;
    t_sel_low = 1'b1;
    t_dec     = 1'b0;
    case (ph)
      PH_IDLE: begin
        if (run_en && !arb_lost) begin
          ph_nx  = PH_LOW;
          t_load = 1'b1;
        end
      end
      PH_LOW: begin
        if (t_expired) ph_nx = PH_WAIT;
        else           t_dec = 1'b1;
      end
      PH_WAIT: begin
        if (scl_rise) begin
          ph_nx     = PH_HIGH;
          t_load    = 1'b1;
          t_sel_low = 1'b0;
        end
      end
      PH_HIGH: begin
        if (conflict) begin
          ph_nx = PH_IDLE;
        end else if (scl_fall || t_expired) begin
          if (run_en) begin
            ph_nx  = PH_LOW;
            t_load = 1'b1;
          end else begin
            ph_nx = PH_IDLE;
          end
        end else begin
          t_dec = 1'b1;
        end
      end
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      arb_lost   <= 1'b0;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else begin
      ph         <= ph_nx;
      arb_lost   <= run_en & (arb_lost | conflict);
      sample_stb <= (ph == PH_WAIT) & scl_rise;
      shift_stb  <= (ph_nx == PH_LOW) & (ph != PH_LOW);
    end
  end

  assign scl_pull = (ph == PH_LOW);
  assign sda_pull = ~sda_bit & ~arb_lost;

endmodule

// File: rtl/scl_pacer_chk.sv
module scl_pacer_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic sda_bit,
  input logic scl_pull,
  input logic sda_pull,
  input logic sample_stb,
  input logic shift_stb,
  input logic arb_lost,
  input logic scl_rise,
  input logic scl_fall,
  input logic in_high
);

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb));

  assert_sample_after_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(scl_rise));

  assert_shift_on_pull_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> shift_stb);

  assert_fall_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && in_high && run_en && !arb_lost && !sda_bit) |=> scl_pull);

  assert_lost_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (!scl_pull && !sda_pull));

  assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !scl_pull) |=> !scl_pull);

  assert_lost_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && run_en) |=> arb_lost);

  assert_lost_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !arb_lost);

endmodule

bind scl_pacer scl_pacer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .sda_bit    (sda_bit),
  .scl_pull   (scl_pull),
  .sda_pull   (sda_pull),
  .sample_stb (sample_stb),
  .shift_stb  (shift_stb),
  .arb_lost   (arb_lost),
  .scl_rise   (scl_rise),
  .scl_fall   (scl_fall),
  .in_high    (in_high)
);

// File: tb/sim_scl_pacer.sv
`timescale 1ns/1ps
module sim_scl_pacer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic [7:0] lo = 8'd4;
  logic [7:0] hi = 8'd5;
  logic ext_scl = 1'b0;
  logic ext_sda = 1'b0;
  logic sda_bit = 1'b1;
  logic scl_pull, sda_pull, sample_stb, shift_stb, arb_lost;
  logic scl_bus, sda_bus;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign scl_bus = ~(scl_pull | ext_scl);
  assign sda_bus = ~(sda_pull | ext_sda);

  scl_pacer u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .low_reload(lo), .high_reload(hi),
    .scl_in(scl_bus), .sda_in(sda_bus), .sda_bit(sda_bit),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .sample_stb(sample_stb), .shift_stb(shift_stb), .arb_lost(arb_lost)
  );

  typedef struct {
    logic  lvl;
    int    dur;
    int    idx;
    string req;
  } phase_t;

  phase_t exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_phase(input logic lvl, input int dur, input int idx, input string req);
    phase_t p;
    p.lvl = lvl; p.dur = dur; p.idx = idx; p.req = req;
    exp_q.push_back(p);
  endtask

  // Monitor: measure each bus clock phase and its strobe position.
  logic cur_lvl = 1'b1;
  int   cur_dur = 0;
  int   cur_idx = -1;
  always @(negedge clk) begin
    phase_t e;
    if (!rst_n) begin
      cur_lvl = 1'b1; cur_dur = 0; cur_idx = -1;
    end else if (scl_bus !== cur_lvl) begin
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(cur_lvl == e.lvl, {e.req, " level"}, int'(cur_lvl), int'(e.lvl));
        chk(cur_dur == e.dur, {e.req, " duration"}, cur_dur, e.dur);
        chk(cur_idx == e.idx, {e.req, " strobe position"}, cur_idx, e.idx);
      end
      cur_lvl = scl_bus;
      cur_dur = 1;
      cur_idx = (scl_bus ? sample_stb : shift_stb) ? 0 : -1;
    end else begin
      cur_dur++;
      if (cur_idx < 0 && (cur_lvl ? sample_stb : shift_stb)) cur_idx = cur_dur - 1;
    end
  end

  task automatic sync_to_fall();
    do @(negedge clk); while (scl_bus !== 1'b1);
    do @(negedge clk); while (scl_bus !== 1'b0);
    #2;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    int pulls;
    int samples;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!scl_pull && !sda_pull, "R1 pulls in reset", int'({scl_pull, sda_pull}), 0);
    chk(!sample_stb && !shift_stb && !arb_lost, "R1 strobes/flag in reset",
        int'({sample_stb, shift_stb, arb_lost}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_pull && !arb_lost, "R1 after reset", int'({scl_pull, arb_lost}), 0);

    // R6: data drive follows bit
    sda_bit = 1'b0; #1;
    chk(sda_pull == 1'b1, "R6 drive zero", int'(sda_pull), 1);
    sda_bit = 1'b1; #1;
    chk(sda_pull == 1'b0, "R6 release one", int'(sda_pull), 0);

    // R2/R3: solo clocking, low 4 high 5
    run_en = 1'b1;
    sync_to_fall();
    expect_phase(1'b0, 4, 0, "R2 low");
    expect_phase(1'b1, 8, 3, "R3 high");
    expect_phase(1'b0, 4, 0, "R2 low");
    expect_phase(1'b1, 8, 3, "R3 high");
    drain();
    chk(!arb_lost, "R7 no loss when bus agrees", int'(arb_lost), 0);

    // R2/R3: minimum reload values
    lo = 8'd1; hi = 8'd1;
    sync_to_fall();
    expect_phase(1'b0, 1, 0, "R2 low min");
    expect_phase(1'b1, 4, 3, "R3 high min");
    expect_phase(1'b0, 1, 0, "R2 low min");
    expect_phase(1'b1, 4, 3, "R3 high min");
    drain();

    // R4: another device stretches the low phase
    lo = 8'd4; hi = 8'd5;
    sync_to_fall();
    sync_to_fall();
    expect_phase(1'b0, 21, 0, "R4 stretched low");
    expect_phase(1'b1, 8, 3, "R4 high after stretch");
    expect_phase(1'b0, 4, 0, "R2 low after stretch");
    @(posedge clk); #1 ext_scl = 1'b1;
    repeat (20) @(posedge clk);
    #1 ext_scl = 1'b0;
    drain();

    // R5: another device cuts the high phase short
    lo = 8'd4; hi = 8'd10;
    sync_to_fall();
    sync_to_fall();
    expect_phase(1'b0, 4, 0, "R2 low");
    expect_phase(1'b1, 5, 3, "R5 shortened high");
    expect_phase(1'b0, 7, 3, "R5 low after external fall");
    expect_phase(1'b1, 13, 3, "R3 high");
    expect_phase(1'b0, 4, 0, "R2 low");
    repeat (9) @(posedge clk);
    #1 ext_scl = 1'b1;
    repeat (4) @(posedge clk);
    #1 ext_scl = 1'b0;
    drain();

    // R8: disable mid low phase
    lo = 8'd4; hi = 8'd5;
    sync_to_fall();
    sync_to_fall();
    run_en = 1'b0;
    expect_phase(1'b0, 4, 0, "R8 last low");
    drain();
    pulls = 0; samples = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (scl_pull) pulls++;
      if (sample_stb) samples++;
    end
    chk(pulls == 0, "R8 no pull after disable", pulls, 0);
    chk(samples == 1, "R8 final high completes", samples, 1);
    chk(scl_bus == 1'b1, "R8 line released", int'(scl_bus), 1);

    // R7/R9: arbitration loss
    ext_sda = 1'b1; sda_bit = 1'b1;
    run_en = 1'b1;
    repeat (30) @(negedge clk);
    chk(arb_lost == 1'b1, "R7 loss flagged", int'(arb_lost), 1);
    sda_bit = 1'b0;
    pulls = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (scl_pull || sda_pull) pulls++;
    end
    chk(pulls == 0, "R7 lines released after loss", pulls, 0);
    chk(arb_lost == 1'b1, "R9 flag held while enabled", int'(arb_lost), 1);
    ext_sda = 1'b0; sda_bit = 1'b1;
    run_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(arb_lost == 1'b0, "R9 flag cleared by disable", int'(arb_lost), 0);

    finished = 1'b1;
    summary();
  end

endmodule